// File: doc/BRIEF.md
# Preset-Slot SPI Register Loader

This block keeps eight fixed register images for a synthesizer chip that is configured over a serial link. A one-cycle start request sends the image picked by a 3-bit slot number. Each image is 64 bits long and goes out as four 16-bit words inside a single chip-select frame. The four words are sent in a fixed order: a control word that holds the synthesizer in reset (0x2100), the low half of a frequency register, the high half of that register, and a control word that lets the synthesizer run again (0x2000). Bits 15:14 of each frequency half carry the register-select code 01, and the other 14 bits carry frequency data. The images are build-time parameters. Bits 63:48 of a slot's entry form the first word, and slot s sits at bits s*64 and up of the table.

The serial timing is SPI mode 2. The clock idles high. Data changes on the rising clock edge and must be stable at the falling edge, where the chip samples it. Three option inputs set the link to suit the board: one inverts the select polarity, one inverts the clock polarity, and one slows the serial clock by a factor of eight. The slot number and the options are captured on the start strobe. While the block is idle, the options follow their inputs.

Top module: `preset_spi_loader`

## Requirements
- R1: After reset the block is idle: busy and done are 0, the select output is 1 (inactive with default polarity), and the serial clock output is 1.
- R2: A start request with slot s sends the 64-bit table entry of slot s, most significant bit first. The first word is bits 63:48 (reset control, 0x2100), then the low frequency half (bits 15:14 = 01), then the high frequency half (bits 15:14 = 01), and last the release word (0x2000).
- R3: The data output changes only while the logical serial clock is high. It is stable from one cycle before each falling edge through the whole low phase.
- R4: Select stays active without a break from before the first falling clock edge until after the 64th bit, so all four words share one frame.
- R5: Exactly one half period passes between select going active and the first falling clock edge. Exactly one half period passes between the last rising edge and select going inactive.
- R6: Each serial clock phase lasts HALF_CYC clock cycles (2 by default). With the slow option set, each phase lasts 8 × HALF_CYC cycles.
- R7: With the select-invert option set, select is active high and idles low. Otherwise it is active low.
- R8: With the clock-invert option set, the serial clock output is the complement of the mode-2 level, so it idles low.
- R9: Busy rises on the edge that follows the start request and falls on the same edge at which select goes inactive. On that edge, done goes high for exactly one cycle.
- R10: A start request made while busy is high is ignored. The frame in progress finishes unchanged, and no second frame follows.
- R11: The slot number is captured with the start request. Changing it during a frame does not change the data that is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_idx | input | 3 | Preset slot to send, captured on start |
| start | input | 1 | One-cycle load request |
| opt_sel_inv | input | 1 | 1: select active high |
| opt_sck_inv | input | 1 | 1: serial clock inverted (idles low) |
| opt_slow | input | 1 | 1: serial clock slowed by 8 |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| spi_sel | output | 1 | Chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data |

## Verification
Every slot is loaded at least once, so a wrong slot decode or a bit-order error shows up as a wrong 64-bit capture. The frames mix the three options, so each polarity and both clock rates appear alone and in combinations. The bench measures the lead, the trail and each phase width, which separates the fast rate from the slow rate and catches a missing setup or hold interval. Directed cases change the slot number during a frame and repeat the start request while busy. These cases separate a design that captures its inputs on start from one that samples them live.

// File: rtl/psl_pkg.sv
package psl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TRAIL
    } phase_e;

    typedef struct packed {
        logic sel_inv;
        logic sck_inv;
        logic slow;
    } link_opts_t;

    // Default table: eight slots of reset word, low half, high half, release word.
    function automatic logic [8*64-1:0] psl_default_images();
        logic [8*64-1:0] tab;
        tab = '0;
        for (int s = 0; s < 8; s++) begin
            tab[s*64 +: 64] = {16'h2100,
                               2'b01, 14'(16'h0A5C + 16'(s) * 16'h0313),
                               2'b01, 14'(16'h0120 + 16'(s)),
                               16'h2000};
        end
        return tab;
    endfunction

endpackage

// File: rtl/psl_timer.sv
module psl_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] lim,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick = !restart && (cnt_q == lim - CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
        if (restart || tick) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R6: a running phase never counts past its length
    a_r6_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> (cnt_q < lim));

endmodule

// File: rtl/psl_shifter.sv
module psl_shifter #(
    parameter int IMG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IMG_W-1:0] img,
    input  logic             shift,
    output logic             mosi,
    output logic             last
);

    localparam int CW = $clog2(IMG_W);

    typedef struct packed {
        logic [IMG_W-1:0] data;
        logic [CW-1:0]    cnt;
    } shreg_t;

    shreg_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d.data = img;
            sh_d.cnt  = '0;
        end else if (shift) begin
            sh_d.data = {sh_q.data[IMG_W-2:0], 1'b0};
            sh_d.cnt  = sh_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign mosi = sh_q.data[IMG_W-1];
    assign last = (sh_q.cnt == CW'(IMG_W - 1));

    // R2: exactly IMG_W bits per image, no shift beyond the final bit
    a_r2_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |-> !last);

endmodule

// File: rtl/psl_image_sel.sv
module psl_image_sel #(
    parameter int                     SLOTS   = 8,
    parameter int                     IMG_W   = 64,
    parameter int                     SLOT_W  = 3,
    parameter logic [SLOTS*IMG_W-1:0] PRESETS = '0
) (
    input  logic [SLOT_W-1:0] slot,
    output logic [IMG_W-1:0]  img
);

    logic [IMG_W-1:0] table_w [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign table_w[g] = PRESETS[g*IMG_W +: IMG_W];
    end

    assign img = table_w[slot];

endmodule

// File: rtl/preset_spi_loader.sv
module preset_spi_loader
    import psl_pkg::*;
#(
    parameter int                     SLOTS    = 8,
    parameter int                     IMG_W    = 64,
    parameter int                     HALF_CYC = 2,
    parameter int                     SLOW_DIV = 8,
    parameter logic [SLOTS*IMG_W-1:0] PRESETS  = psl_default_images()
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] slot_idx,
    input  logic       start,
    input  logic       opt_sel_inv,
    input  logic       opt_sck_inv,
    input  logic       opt_slow,
    output logic       busy,
    output logic       done,
    output logic       spi_sel,
    output logic       spi_sck,
    output logic       spi_mosi
);

    localparam int SLOT_W = 3;
    localparam int CNT_W  = $clog2(HALF_CYC * SLOW_DIV + 1);

    typedef struct packed {
        phase_e            phase;
        logic [SLOT_W-1:0] slot;
        link_opts_t        opt;
        logic              sel_act;
        logic              sck_lvl;
        logic              done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tick, last, load, shift;
    logic [CNT_W-1:0] lim;
    logic [IMG_W-1:0] img;

    assign lim = ctl_q.opt.slow ? CNT_W'(HALF_CYC * SLOW_DIV) : CNT_W'(HALF_CYC);

    psl_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctl_q.phase == PH_IDLE),
        .lim     (lim),
        .tick    (tick)
    );

    psl_image_sel #(
        .SLOTS   (SLOTS),
        .IMG_W   (IMG_W),
        .SLOT_W  (SLOT_W),
        .PRESETS (PRESETS)
    ) i_image_sel (
        .slot (slot_idx),
        .img  (img)
    );

    psl_shifter #(.IMG_W(IMG_W)) i_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .img   (img),
        .shift (shift),
        .mosi  (spi_mosi),
        .last  (last)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load       = 1'b0;
        shift      = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                ctl_d.opt = '{sel_inv: opt_sel_inv, sck_inv: opt_sck_inv, slow: opt_slow};
                if (start) begin
                    ctl_d.slot    = slot_idx;
                    ctl_d.phase   = PH_LEAD;
                    ctl_d.sel_act = 1'b1;
                    ctl_d.sck_lvl = 1'b1;
                    load          = 1'b1;
                end
            end
            PH_LEAD: begin
                if (tick) begin
                    ctl_d.phase   = PH_LOW;
                    ctl_d.sck_lvl = 1'b0;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    ctl_d.sck_lvl = 1'b1;
                    if (last) begin
                        ctl_d.phase = PH_TRAIL;
                    end else begin
                        ctl_d.phase = PH_HIGH;
                        shift       = 1'b1;
                    end
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    ctl_d.phase   = PH_LOW;
                    ctl_d.sck_lvl = 1'b0;
                end
            end
            PH_TRAIL: begin
                if (tick) begin
                    ctl_d.phase   = PH_IDLE;
                    ctl_d.sel_act = 1'b0;
                    ctl_d.done    = 1'b1;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.phase   <= PH_IDLE;
            ctl_q.sck_lvl <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = (ctl_q.phase != PH_IDLE);
    assign done    = ctl_q.done;
    assign spi_sel = ctl_q.opt.sel_inv ? ctl_q.sel_act : !ctl_q.sel_act;
    assign spi_sck = ctl_q.sck_lvl ^ ctl_q.opt.sck_inv;

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done coincides with the end of busy
    a_r9_done_at_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10 / R11: captured slot and options hold while busy
    a_r11_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ctl_q.slot) && $stable(ctl_q.opt)));

    // R3: serial data stays put through the low clock phase
    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !ctl_q.sck_lvl) |-> $stable(spi_mosi));

    // R4: select stays active for the whole frame
    a_r4_frame_select: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $past(ctl_q.sel_act));

endmodule

// File: tb/test_preset_spi_loader.sv
module test_preset_spi_loader;

    localparam int H = 2;
    localparam logic [8*64-1:0] TAB = {
        64'h2100_7F48_4DF6_2000, 64'h2100_5BDA_4DF0_2000,
        64'h2100_786C_4DE9_2000, 64'h2100_54FE_4DE3_2000,
        64'h2100_7190_4DDC_2000, 64'h2100_4E22_4DD6_2000,
        64'h2100_6AB3_4DCF_2000, 64'h2100_62B7_4DFD_2000};

    // {slot[2:0], sel_inv, sck_inv, slow}
    localparam logic [5:0] VEC [10] = '{
        6'b000_000, 6'b001_000, 6'b010_100, 6'b011_010, 6'b100_001,
        6'b101_110, 6'b110_011, 6'b111_101, 6'b000_111, 6'b111_000};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [2:0] slot_idx = '0;
    logic si = 1'b0, ki = 1'b0, sl = 1'b0;
    logic busy, done, spi_sel, spi_sck, spi_mosi;

    int n_chk = 0, n_bad = 0;

    always #4 clk = !clk;

    preset_spi_loader #(.HALF_CYC(H), .PRESETS(TAB)) i_preset_spi_loader (
        .clk(clk), .rst_n(rst_n), .slot_idx(slot_idx), .start(start),
        .opt_sel_inv(si), .opt_sck_inv(ki), .opt_slow(sl),
        .busy(busy), .done(done), .spi_sel(spi_sel), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi));

    // frame monitor
    logic [63:0] cap;
    int nbits, run, lead, trail, wmin, wmax, hold_bad, n_done, done_long, done_busy_bad, frames;
    logic p_act = 1'b0, p_sck = 1'b1, p_mosi = 1'b0, p_done = 1'b0, p_busy = 1'b0, first;

    always @(negedge clk) begin
        logic act, lsck;
        act  = si ? spi_sel : !spi_sel;
        lsck = spi_sck ^ ki;
        if (act && !p_act) begin
            cap = '0; nbits = 0; run = 0; first = 1'b1;
            wmin = 1 << 20; wmax = 0; hold_bad = 0;
        end else begin
            run++;
        end
        if (act && p_act && lsck != p_sck) begin
            if (first) begin
                lead = run; first = 1'b0;
            end else begin
                if (run < wmin) wmin = run;
                if (run > wmax) wmax = run;
            end
            if (!lsck) begin
                cap = {cap[62:0], spi_mosi}; nbits++;
            end
            run = 0;
        end
        if (act && p_act && !lsck && !p_sck && spi_mosi != p_mosi) hold_bad++;
        if (!act && p_act) begin
            trail = run; frames++;
        end
        if (done) begin
            n_done++;
            if (p_done) done_long++;
            if (busy || !p_busy) done_busy_bad++;
        end
        p_act = act; p_sck = lsck; p_mosi = spi_mosi; p_done = done; p_busy = busy;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        @(negedge clk); @(negedge clk);
    endtask

    task automatic run_frame(input logic [2:0] s, input logic a, input logic b, input logic c);
        bit ok;
        int hp;
        @(negedge clk);
        slot_idx = s; si = a; ki = b; sl = c;
        n_done = 0; done_long = 0; done_busy_bad = 0;
        repeat (3) @(negedge clk);
        pulse_start();
        chk("R9 busy after start", 64'(busy), 64'd1);
        wait_done(ok);
        chk("R9 frame completed", 64'(ok), 64'd1);
        hp = c ? H * 8 : H;
        chk("R2 image", cap, TAB[s*64 +: 64]);
        chk("R4 bits in one frame", 64'(nbits), 64'd64);
        chk("R5 lead", 64'(lead), 64'(hp));
        chk("R5 trail", 64'(trail), 64'(hp));
        chk("R6 min phase", 64'(wmin), 64'(hp));
        chk("R6 max phase", 64'(wmax), 64'(hp));
        chk("R3 data hold", 64'(hold_bad), 64'd0);
        chk("R9 one done", 64'(n_done), 64'd1);
        chk("R9 done width", 64'(done_long), 64'd0);
        chk("R9 done at busy fall", 64'(done_busy_bad), 64'd0);
        chk("R7 idle select", 64'(spi_sel), 64'(!a));
        chk("R8 idle clock", 64'(spi_sck), 64'(!b));
    endtask

    initial begin
        frames = 0;
        repeat (3) @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 select", 64'(spi_sel), 64'd1);
        chk("R1 clock", 64'(spi_sck), 64'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 10; v++) begin
            run_frame(VEC[v][5:3], VEC[v][2], VEC[v][1], VEC[v][0]);
        end

        // R7 / R8: active levels during a frame
        begin
            bit ok;
            @(negedge clk); slot_idx = 3'd4; si = 1'b1; ki = 1'b1; sl = 1'b0;
            repeat (2) @(negedge clk);
            pulse_start();
            chk("R7 active high select", 64'(spi_sel), 64'd1);
            chk("R8 inverted clock idle phase", 64'(spi_sck), 64'd0);
            wait_done(ok);
            chk("R2 image inverted link", cap, TAB[4*64 +: 64]);
        end

        // R10 / R11: slot change and repeated start during a frame
        begin
            bit ok;
            int fr0;
            @(negedge clk); slot_idx = 3'd2; si = 1'b0; ki = 1'b0; sl = 1'b0;
            n_done = 0;
            repeat (2) @(negedge clk);
            fr0 = frames;
            pulse_start();
            repeat (10) @(negedge clk);
            slot_idx = 3'd5;
            pulse_start();
            wait_done(ok);
            chk("R11 slot captured on start", cap, TAB[2*64 +: 64]);
            repeat (40) @(negedge clk);
            chk("R10 no second frame", 64'(frames - fr0), 64'd1);
            chk("R10 single done", 64'(n_done), 64'd1);
            chk("R10 idle after frame", 64'(busy), 64'd0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule